// File: doc/BRIEF.md
# Mode-Selectable Bidirectional Shift Register

This block is a clocked register of `W` bits, four by default. A two-bit mode input chooses what happens to the register on each rising clock edge. The register can take a whole word from a parallel bus, move every bit one place toward the higher index, move every bit one place toward the lower index, or keep its value. Each shift direction has its own serial input, which fills the bit position that the shift empties.

The bit at each end of the register drives a serial output, so several of these registers can be joined end to end. When the register is fed one bit per clock and then read on its parallel outputs, it converts a serial stream into a parallel word. The mode encoding puts the parallel load on code 00 and the hold on code 11.

Top module: `shreg_bidir`

## Requirements
- R1: A low level on `rst_n` at a rising clock edge clears every bit of `data_q` to 0. This reset takes priority over every mode code.
- R2: With `mode` = 2'b00 at a clock edge, `data_q` takes the value of `par_in`.
- R3: With `mode` = 2'b01 at a clock edge, bit i of `data_q` takes the old bit i-1 for i from 1 to W-1, and bit 0 takes `ser_in_lo`.
- R4: With `mode` = 2'b10 at a clock edge, bit i of `data_q` takes the old bit i+1 for i from 0 to W-2, and bit W-1 takes `ser_in_hi`.
- R5: With `mode` = 2'b11 at a clock edge, `data_q` keeps its value. `par_in`, `ser_in_lo` and `ser_in_hi` have no effect.
- R6: `ser_out_hi` always equals `data_q[W-1]` and `ser_out_lo` always equals `data_q[0]`, with no extra clock of delay.
- R7: A single 1 entered on `ser_in_lo` into an all-zero register moves one stage on each up-shift edge. It first appears at `data_q[W-1]` on the W-th up-shift edge, counting the edge that took it in.
- R8: After W up-shift edges, `data_q` holds the W serial bits as one word. The first bit entered sits at bit W-1 and the last bit entered sits at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode | input | 2 | Operation code: 00 load, 01 shift up, 10 shift down, 11 hold |
| par_in | input | W | Parallel word used by the load operation |
| ser_in_lo | input | 1 | Serial bit that enters bit 0 during a shift up |
| ser_in_hi | input | 1 | Serial bit that enters bit W-1 during a shift down |
| data_q | output | W | Current register contents |
| ser_out_hi | output | 1 | Top bit of the register, for chaining during a shift up |
| ser_out_lo | output | 1 | Bottom bit of the register, for chaining during a shift down |

## Verification
The bench targets the mode encoding that is easy to get wrong. If load and hold were swapped to the more common arrangement, the load test would see the register keep its value, and the hold test would see it take a new word. It drives active values on `par_in` and on both serial inputs while in hold, and applies reset with the load code and an all-ones word, so a hold that leaks input or a reset that loses priority is caught. Walking a lone 1 in each direction and converting a serial stream exposes two faults: a wrong fill bit at either end, and an off-by-one stage link.

// File: rtl/shreg_pkg.sv
// Package: shared mode codes and decoded select type for the shift register.
// Assumes: mode codes are fixed by the block's contract (00 load, 11 hold).
package shreg_pkg;

    typedef enum logic [1:0] {
        MODE_LOAD = 2'b00,
        MODE_UP   = 2'b01,
        MODE_DOWN = 2'b10,
        MODE_HOLD = 2'b11
    } mode_e;

    // One-hot operation select, produced once and fanned out to every cell.
    typedef struct packed {
        logic load;
        logic up;
        logic down;
        logic hold;
    } sel_t;

endpackage

// File: rtl/shreg_mode_dec.sv
// Module: shreg_mode_dec
// Turns the two-bit mode code into a one-hot select shared by all cells.
// Assumes: mode is a plain two-bit code; every code maps to exactly one operation.
module shreg_mode_dec
    import shreg_pkg::*;
(
    input  logic [1:0] mode,
    output sel_t       sel
);

    // Decode the mode code into one select line.
    always_comb begin
        sel = '0;
        unique case (mode_e'(mode))
            MODE_LOAD: sel.load = 1'b1;
            MODE_UP:   sel.up   = 1'b1;
            MODE_DOWN: sel.down = 1'b1;
            MODE_HOLD: sel.hold = 1'b1;
            default:   sel.hold = 1'b1;
        endcase
    end

endmodule

// File: rtl/shreg_cell.sv
// Module: shreg_cell
// One storage stage: picks own value, parallel bit, lower neighbour or
// upper neighbour by the one-hot select, and registers it.
// Assumes: sel is one-hot; rst_n is synchronous and active low.
module shreg_cell
    import shreg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  sel_t sel,
    input  logic par_bit,
    input  logic from_below,
    input  logic from_above,
    output logic bit_q
);

    logic bit_d;

    // Select the next value of this stage from the one-hot select.
    always_comb begin
        bit_d = bit_q;
        if (sel.load)      bit_d = par_bit;
        else if (sel.up)   bit_d = from_below;
        else if (sel.down) bit_d = from_above;
    end

    // Store the stage value; reset wins over every mode.
    always_ff @(posedge clk) begin
        if (!rst_n) bit_q <= 1'b0;
        else        bit_q <= bit_d;
    end

endmodule

// File: rtl/shreg_bidir.sv
// Module: shreg_bidir (top)
// W-bit register with load, shift up, shift down and hold, chosen by mode.
// Assumes: W >= 2; synchronous active-low reset; end bits exported for chaining.
module shreg_bidir
    import shreg_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   mode,
    input  logic [W-1:0] par_in,
    input  logic         ser_in_lo,
    input  logic         ser_in_hi,
    output logic [W-1:0] data_q,
    output logic         ser_out_hi,
    output logic         ser_out_lo
);

    localparam int MSB = W - 1;

    sel_t sel;

    shreg_mode_dec u_dec (
        .mode (mode),
        .sel  (sel)
    );

    // One cell per bit; the end cells take the serial inputs as neighbours.
    for (genvar i = 0; i < W; i++) begin : g_cell
        logic below;
        logic above;

        if (i == 0) begin : g_lo_end
            assign below = ser_in_lo;
        end else begin : g_lo_mid
            assign below = data_q[i-1];
        end

        if (i == MSB) begin : g_hi_end
            assign above = ser_in_hi;
        end else begin : g_hi_mid
            assign above = data_q[i+1];
        end

        shreg_cell u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .sel        (sel),
            .par_bit    (par_in[i]),
            .from_below (below),
            .from_above (above),
            .bit_q      (data_q[i])
        );
    end

    // Expose the end bits for chaining registers.
    assign ser_out_hi = data_q[MSB];
    assign ser_out_lo = data_q[0];

endmodule

// File: rtl/shreg_bidir_chk.sv
// Module: shreg_bidir_chk
// Clocked properties on the top module's ports, attached by bind.
// Assumes: W >= 2.
module shreg_bidir_chk #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic [1:0]   mode,
    input logic [W-1:0] par_in,
    input logic         ser_in_lo,
    input logic         ser_in_hi,
    input logic [W-1:0] data_q
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (data_q == '0));

    // R2
    load_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00) |=> (data_q == $past(par_in)));

    // R3
    shift_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01) |=>
        (data_q == (($past(data_q) << 1) | {{(W-1){1'b0}}, $past(ser_in_lo)})));

    // R4
    shift_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10) |=>
        (data_q == (($past(data_q) >> 1) | ({{(W-1){1'b0}}, $past(ser_in_hi)} << (W-1)))));

    // R5
    hold_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11) |=> $stable(data_q));

endmodule

bind shreg_bidir shreg_bidir_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .par_in    (par_in),
    .ser_in_lo (ser_in_lo),
    .ser_in_hi (ser_in_hi),
    .data_q    (data_q)
);

// File: tb/shreg_bidir_tb.sv
`timescale 1ns/1ps
module shreg_bidir_tb;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [1:0]   mode;
    logic [W-1:0] par_in;
    logic         ser_in_lo;
    logic         ser_in_hi;
    logic [W-1:0] data_q;
    logic         ser_out_hi;
    logic         ser_out_lo;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Reference model: element k of the queue is bit k of the register.
    bit model[$];

    always #2.5 clk = ~clk;

    shreg_bidir #(.W(W)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .par_in     (par_in),
        .ser_in_lo  (ser_in_lo),
        .ser_in_hi  (ser_in_hi),
        .data_q     (data_q),
        .ser_out_hi (ser_out_hi),
        .ser_out_lo (ser_out_lo)
    );

    function automatic logic [W-1:0] model_word();
        logic [W-1:0] w;
        for (int k = 0; k < W; k++) w[k] = model[k];
        return w;
    endfunction

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Compare the whole port view against the model (end taps are R6).
    task automatic compare(string req);
        check(req, data_q, model_word());
        check("R6", {ser_out_hi, ser_out_lo}, {model[W-1], model[0]});
    endtask

    // Drive one cycle at the falling edge, update the model at the rising
    // edge, then compare at the next falling edge.
    task automatic step(string req, logic r, logic [1:0] m, logic [W-1:0] d,
                        logic sl, logic sh);
        rst_n = r; mode = m; par_in = d; ser_in_lo = sl; ser_in_hi = sh;
        @(posedge clk);
        if (!r) begin
            for (int k = 0; k < W; k++) model[k] = 1'b0;
        end else begin
            case (m)
                2'b00: for (int k = 0; k < W; k++) model[k] = d[k];
                2'b01: begin model.push_front(sl); void'(model.pop_back()); end
                2'b10: begin model.push_back(sh); void'(model.pop_front()); end
                default: ;
            endcase
        end
        @(negedge clk);
        compare(req);
    endtask

    initial begin
        for (int k = 0; k < W; k++) model.push_back(1'b0);
        rst_n = 1'b0; mode = 2'b11; par_in = '0; ser_in_lo = 1'b0; ser_in_hi = 1'b0;
        @(negedge clk);
        // R1: reset with load code and all-ones word must still clear
        step("R1", 1'b0, 2'b00, '1, 1'b1, 1'b1);
        step("R1", 1'b0, 2'b01, '1, 1'b1, 1'b1);

        // R2: several load patterns
        step("R2", 1'b1, 2'b00, 4'b1010, 1'b0, 1'b0);
        step("R2", 1'b1, 2'b00, 4'b0110, 1'b1, 1'b1);
        step("R2", 1'b1, 2'b00, 4'b1111, 1'b0, 1'b1);

        // R5: hold ignores active inputs
        step("R5", 1'b1, 2'b11, 4'b0000, 1'b0, 1'b0);
        step("R5", 1'b1, 2'b11, 4'b0101, 1'b1, 1'b0);
        step("R5", 1'b1, 2'b11, 4'b1001, 1'b0, 1'b1);

        // R3: shift up with mixed fill bits
        step("R2", 1'b1, 2'b00, 4'b1001, 1'b0, 1'b0);
        step("R3", 1'b1, 2'b01, 4'b1111, 1'b1, 1'b0);
        step("R3", 1'b1, 2'b01, 4'b0000, 1'b0, 1'b1);
        step("R3", 1'b1, 2'b01, 4'b1111, 1'b1, 1'b1);

        // R4: shift down with mixed fill bits
        step("R2", 1'b1, 2'b00, 4'b0110, 1'b0, 1'b0);
        step("R4", 1'b1, 2'b10, 4'b1111, 1'b0, 1'b1);
        step("R4", 1'b1, 2'b10, 4'b0000, 1'b1, 1'b0);
        step("R4", 1'b1, 2'b10, 4'b1111, 1'b0, 1'b1);

        // R7: walk a lone 1 up; top bit must rise on exactly the W-th edge
        step("R2", 1'b1, 2'b00, '0, 1'b0, 1'b0);
        for (int n = 1; n <= W; n++) begin
            step("R7", 1'b1, 2'b01, '0, (n == 1), 1'b0);
            check("R7", {{(W-1){1'b0}}, ser_out_hi}, {{(W-1){1'b0}}, (n == W)});
        end
        // walk it back down to the bottom
        for (int n = 1; n < W; n++) step("R4", 1'b1, 2'b10, '0, 1'b0, 1'b0);
        check("R4", data_q, {{(W-1){1'b0}}, 1'b1});

        // R8: serial-to-parallel, first bit ends at MSB
        begin
            logic [W-1:0] stream = 4'b1011; // stream[W-1] entered first
            for (int n = W - 1; n >= 0; n--)
                step("R8", 1'b1, 2'b01, '0, stream[n], 1'b0);
            check("R8", data_q, stream);
        end

        // R1: reset in mid-operation
        step("R1", 1'b0, 2'b10, '1, 1'b1, 1'b1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all R) actual=timeout expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule